// File: doc/BRIEF.md
# Interlocked Cross-Clock Request/Acknowledge Link

This block joins two clock domains with a return-to-zero handshake. On one side, a requester accepts a data word from local logic. It drives that word onto a shared bus and raises a request line. On the other side, a responder takes the word and works on it for a fixed number of its own clock cycles. It then posts a result and raises an acknowledge line. The requester captures the result and drops request. The responder drops acknowledge only after it has seen request go low. A new transfer cannot start on the requester side until acknowledge has been seen low again.

Each side sees the other's control line only through a two-stage flip-flop synchronizer. The data and result buses are not synchronized. Each bus is held still by its owner whenever the other side may sample it: the word from request rise until acknowledge is seen, and the result for as long as acknowledge is high. Local logic on the requester side sees a busy flag, a one-cycle completion pulse and the captured result. The responder side shows a one-cycle strobe along with each word it takes in. The result is the word plus a constant offset, modulo 2^W.

Top module: `hs4_link`

## Requirements
- R1: While `rst_a` and `rst_b` are held, and on the first cycles after reset, `busy`, `done` and `rsp_strobe` are 0 and `rx_result` is 0.
- R2: A one-cycle `start` while `busy` is 0 captures `tx_word` on that `clk_a` edge, and `busy` reads 1 from the following cycle.
- R3: `start` pulses while `busy` is 1 are ignored: their words never reach the responder, and the transfer in flight completes with its own word.
- R4: For each transfer, the responder pulses `rsp_strobe` for exactly one `clk_b` cycle with `rsp_word` equal to the word sent. It computes result = (word + SALT) mod 2^W.
- R5: `rsp_strobe` comes no sooner than LAT+2 `clk_b` cycles after the `start` that begins the transfer: two synchronizer stages, then LAT processing cycles.
- R6: `done` is a single `clk_a` cycle pulse, and `busy` is 0 in the cycle it is high. At that point `rx_result` equals (word + SALT) mod 2^W, and it holds that value until the next `done`.
- R7: The word driven toward the responder does not change while request is high.
- R8: The responder's result does not change while acknowledge is high.
- R9: Request rises only while the synchronized acknowledge is low, and falls only after acknowledge has been seen high. Acknowledge rises only while the synchronized request is high, and falls only after request has been seen low.
- R10: When the two sides run on clocks of different periods, every accepted word reaches the responder exactly once and in the order accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Requester-side clock |
| rst_a | input | 1 | Requester-side synchronous active-high reset |
| start | input | 1 | Begin a transfer with `tx_word` (ignored while busy) |
| tx_word | input | W | Word to send |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when a transfer has fully completed |
| rx_result | output | W | Last captured result |
| clk_b | input | 1 | Responder-side clock |
| rst_b | input | 1 | Responder-side synchronous active-high reset |
| rsp_strobe | output | 1 | One-cycle pulse when the responder produces a result |
| rsp_word | output | W | Word the responder just processed |

## Verification
The hardest case to reach is a `start` that arrives while a transfer is still draining. This includes the window after the requester has dropped request but before acknowledge has been seen low, where a careless design could let a second word slip through or send one word twice. The bench pokes an extra `start` with a junk word at several points during each transfer, including the drain phase. Because the two clocks have unrelated periods, these pokes land at shifting phases. A responder-side monitor then checks that only the intended words show up, one strobe each, in sequence.

// File: rtl/hs4_pkg.sv
package hs4_pkg;
  typedef enum logic [1:0] {RQ_IDLE, RQ_WAIT, RQ_DRAIN} rq_state_t;
  typedef enum logic [1:0] {RS_IDLE, RS_WORK, RS_HOLD} rs_state_t;
endpackage

// File: rtl/hs4_sync2.sv
module hs4_sync2 (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta;
  // the async input feeds only this first flop
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hs4_requester.sv
module hs4_requester import hs4_pkg::*; #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] tx_word,
  input  logic         ack_async,
  input  logic [W-1:0] rsp_result,
  output logic         req,
  output logic [W-1:0] req_word,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_result
);
  logic      ack_s;
  rq_state_t st;

  hs4_sync2 u_ack_sync (.clk(clk), .rst(rst), .d(ack_async), .q(ack_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RQ_IDLE;
      req       <= 1'b0;
      req_word  <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      rx_result <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        RQ_IDLE: if (start && !ack_s) begin
          req_word <= tx_word;
          req      <= 1'b1;
          busy     <= 1'b1;
          st       <= RQ_WAIT;
        end
        RQ_WAIT: if (ack_s) begin
          rx_result <= rsp_result;
          req       <= 1'b0;
          st        <= RQ_DRAIN;
        end
        RQ_DRAIN: if (!ack_s) begin
          busy <= 1'b0;
          done <= 1'b1;
          st   <= RQ_IDLE;
        end
        default: st <= RQ_IDLE;
      endcase
    end
  end

  p_word_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (req && $past(req)) |-> $stable(req_word));
  p_req_rise_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> !$past(ack_s));
  p_req_fall_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(req) |-> $past(ack_s));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !req));
endmodule

// File: rtl/hs4_responder.sv
module hs4_responder import hs4_pkg::*; #(
  parameter int W    = 8,
  parameter int LAT  = 3,
  parameter int SALT = 37
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_async,
  input  logic [W-1:0] req_word,
  output logic         ack,
  output logic [W-1:0] rsp_result,
  output logic         rsp_strobe,
  output logic [W-1:0] rsp_word
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  logic          req_s;
  rs_state_t     st;
  logic [CW-1:0] cnt;
  logic [W-1:0]  word_q;

  hs4_sync2 u_req_sync (.clk(clk), .rst(rst), .d(req_async), .q(req_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= RS_IDLE;
      cnt        <= '0;
      word_q     <= '0;
      ack        <= 1'b0;
      rsp_result <= '0;
      rsp_strobe <= 1'b0;
      rsp_word   <= '0;
    end else begin
      rsp_strobe <= 1'b0;
      case (st)
        RS_IDLE: if (req_s) begin
          word_q <= req_word;
          cnt    <= CW'(LAT - 1);
          st     <= RS_WORK;
        end
        RS_WORK: if (cnt == '0) begin
          rsp_result <= word_q + W'(SALT);
          rsp_word   <= word_q;
          rsp_strobe <= 1'b1;
          ack        <= 1'b1;
          st         <= RS_HOLD;
        end else begin
          cnt <= cnt - 1'b1;
        end
        RS_HOLD: if (!req_s) begin
          ack <= 1'b0;
          st  <= RS_IDLE;
        end
        default: st <= RS_IDLE;
      endcase
    end
  end

  p_result_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (ack && $past(ack)) |-> $stable(rsp_result));
  p_ack_rise_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(req_s));
  p_ack_fall_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(ack) |-> !$past(req_s));
  p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_strobe |=> !rsp_strobe);
endmodule

// File: rtl/hs4_link.sv
module hs4_link #(
  parameter int W    = 8,
  parameter int LAT  = 3,
  parameter int SALT = 37
) (
  input  logic         clk_a,
  input  logic         rst_a,
  input  logic         start,
  input  logic [W-1:0] tx_word,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_result,
  input  logic         clk_b,
  input  logic         rst_b,
  output logic         rsp_strobe,
  output logic [W-1:0] rsp_word
);
  logic         req, ack;
  logic [W-1:0] req_word, rsp_result;

  hs4_requester #(.W(W)) u_req (
    .clk(clk_a), .rst(rst_a), .start(start), .tx_word(tx_word),
    .ack_async(ack), .rsp_result(rsp_result), .req(req), .req_word(req_word),
    .busy(busy), .done(done), .rx_result(rx_result)
  );

  hs4_responder #(.W(W), .LAT(LAT), .SALT(SALT)) u_rsp (
    .clk(clk_b), .rst(rst_b), .req_async(req), .req_word(req_word),
    .ack(ack), .rsp_result(rsp_result), .rsp_strobe(rsp_strobe),
    .rsp_word(rsp_word)
  );
endmodule

// File: tb/test_hs4_link.sv
`timescale 1ns/1ps
module test_hs4_link;
  localparam int W = 8, LAT = 3, SALT = 37, NW = 48;

  logic clk_a = 0, clk_b = 0, rst_a = 1, rst_b = 1, start = 0;
  logic [W-1:0] tx_word = '0;
  logic busy, done, rsp_strobe;
  logic [W-1:0] rx_result, rsp_word;

  always #2.5 clk_a = ~clk_a;
  always #3.6 clk_b = ~clk_b;

  hs4_link #(.W(W), .LAT(LAT), .SALT(SALT)) i_hs4_link (
    .clk_a(clk_a), .rst_a(rst_a), .start(start), .tx_word(tx_word),
    .busy(busy), .done(done), .rx_result(rx_result),
    .clk_b(clk_b), .rst_b(rst_b), .rsp_strobe(rsp_strobe), .rsp_word(rsp_word)
  );

  int tests = 0, fails = 0;
  logic [W-1:0] sent [NW];
  int nsent = 0, nseen = 0;
  longint bcyc = 0;
  longint t0 [NW];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk_b) bcyc <= bcyc + 1;

  // responder-side monitor: R4, R5, R10
  always @(negedge clk_b) begin
    if (!rst_b && rsp_strobe) begin
      chk(nseen < nsent, "R10 extra word", nseen, nsent);
      if (nseen < nsent) begin
        chk(rsp_word == sent[nseen], "R10 order/R3 junk", rsp_word, sent[nseen]);
        chk(bcyc - t0[nseen] >= LAT + 2, "R5 latency", bcyc - t0[nseen], LAT + 2);
      end
      nseen++;
    end
  end

  task automatic send(input logic [W-1:0] w, input int poke_at);
    logic [W-1:0] exp = w + W'(SALT);
    int n = 0;
    bit got = 0;
    @(negedge clk_a);
    start = 1; tx_word = w;
    sent[nsent] = w; t0[nsent] = bcyc; nsent++;
    @(negedge clk_a);
    start = 0; tx_word = ~w;
    chk(busy == 1'b1, "R2 busy", busy, 1);
    while (!got && n < 400) begin
      if (n == poke_at && !done) begin start = 1; tx_word = w ^ 8'h5A; end
      else start = 0;
      @(negedge clk_a);
      n++;
      if (done) got = 1;
    end
    start = 0;
    chk(got, "R6 done seen", got, 1);
    chk(busy == 1'b0, "R6 busy low at done", busy, 0);
    chk(rx_result == exp, "R4/R6 result", rx_result, exp);
    @(negedge clk_a);
    chk(done == 1'b0, "R6 done one cycle", done, 0);
    repeat (3) @(negedge clk_a);
    chk(rx_result == exp, "R6 result held", rx_result, exp);
  endtask

  initial begin
    repeat (6) @(negedge clk_a);
    chk(busy == 0 && done == 0 && rx_result == 0, "R1 reset a", rx_result, 0);
    chk(rsp_strobe == 0, "R1 reset b", rsp_strobe, 0);
    @(negedge clk_b); rst_b = 0;
    @(negedge clk_a); rst_a = 0;
    @(negedge clk_a);
    chk(busy == 0 && done == 0, "R1 after reset", busy, 0);
    for (int i = 0; i < NW; i++) begin
      logic [W-1:0] w = W'((i * 53 + 7) % 256);
      if (i == 0) w = '0;
      if (i == 1) w = '1;
      send(w, (i % 6 == 5) ? 1000 : (i * 3) % 17);
    end
    repeat (20) @(negedge clk_b);
    chk(nseen == nsent, "R10 count exactly once", nseen, nsent);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule